// File: doc/BRIEF.md
# Serial NOR Flash Command Engine

This block is a byte-level behavioural model of a serial NOR flash device, written as synthesizable RTL. A host frames each transaction. A start strobe carries the opcode byte, and an end strobe closes the frame in the way a chip-select release would. Between the two the host pushes address and data bytes and requests returned bytes. The engine decodes the opcode, gathers a 3- or 4-byte big-endian address, and acts on a byte-wide storage array and a two-bit status register. The supported actions are read, page program, region erase, chip erase, write enable, status read, identification read, and switching between 3- and 4-byte addressing.

The array is held in a simple dual-port memory with no reset, so that block RAM can be inferred. Whole-array and region fills with 0xFF are done by a sweeper that writes one byte per clock. While the sweeper runs, `o_busy` is high. This happens after reset and after every accepted erase. Programming is a read-modify-write that can only clear bits, and its address wraps inside a 256-byte page. Each returned byte appears one clock after its request. Protocol misuse gives a one-cycle error pulse.

Top module: `nor_cmd_engine`

## Requirements
- R1: After reset the sweeper fills every byte of the array with 0xFF while `o_busy` is high. Once it finishes, the status byte reads 0x00 and 3-byte addressing is active.
- R2: The status byte has bit 0 = write in progress (WIP), bit 1 = write-enable latch (WEN), and the other bits are 0. Opcode 0x06 sets WEN.
- R3: Opcode 0x05 returns the status byte for each request and clears WIP after it returns the byte.
- R4: Opcode 0x9F returns 0x55, 0xAA, 0x55 for its first three requests and 0x00 for every request after that.
- R5: Address bytes are taken most significant first. Opcode 0xB7 selects 4-byte addresses and 0xE9 selects 3-byte addresses. A read request before the last address byte is an error.
- R6: Opcode 0x03 returns the bytes from the address upward, one per request. Every `i_rd_req` is answered by `o_rd_vld` in the next cycle.
- R7: Opcode 0x02 ANDs each data byte into the stored byte, so bits only go from 1 to 0.
- R8: During page program the low 8 address bits increment and wrap, and the upper bits stay fixed.
- R9: A program or region erase (0x20, 0x52, 0xD8) or a chip erase (0x60) issued while WEN is clear leaves both the array and the status unchanged.
- R10: Opcodes 0x20, 0x52 and 0xD8 fill the aligned 4 KiB, 32 KiB or 64 KiB region that contains the address with 0xFF, clipped to the array. Opcode 0x60 fills the whole array. `o_busy` is high during the fill.
- R11: An erase sets WIP and clears WEN once its command is complete. A program does the same at its frame end.
- R12: `o_err` pulses one cycle after any of these: an unknown opcode, an opcode while a command is open, a read or program at an address at or beyond the array size, or a byte or request in a state that takes none. An out-of-range read returns 0x00.
- R13: A frame end always returns the engine to idle, so a new opcode after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_start | input | 1 | Frame start; `i_wr_byte` holds the opcode |
| i_wr_vld | input | 1 | Address or data byte valid |
| i_wr_byte | input | 8 | Opcode, address or data byte |
| i_rd_req | input | 1 | Request one returned byte |
| i_end | input | 1 | Frame end |
| o_rd_vld | output | 1 | Returned byte valid (one cycle after request) |
| o_rd_byte | output | 8 | Returned byte |
| o_err | output | 1 | One-cycle protocol error pulse |
| o_busy | output | 1 | Fill sweep in progress |

## Verification
The assertions assume a well-behaved host. In any cycle it raises at most one of start, byte, request and end. While `o_busy` is high it sends no opcode, byte or request, and only a frame end may arrive then. The bench meets these rules by construction: each task drives a single strobe for one clock, and the bench waits for `o_busy` to fall after reset and after every accepted erase. Error cases are created only through legal strobe patterns, such as a misplaced opcode, an early read request or an out-of-range address, so the block's error reporting is tested without breaking the host contract.

// File: rtl/nce_pkg.sv
package nce_pkg;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_STAT  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_ER4K  = 8'h20;
  localparam logic [7:0] OP_ER32K = 8'h52;
  localparam logic [7:0] OP_CHIP  = 8'h60;
  localparam logic [7:0] OP_IDENT = 8'h9F;
  localparam logic [7:0] OP_WIDE  = 8'hB7;
  localparam logic [7:0] OP_ER64K = 8'hD8;
  localparam logic [7:0] OP_NARROW = 8'hE9;

  typedef enum logic [3:0] {
    S_IDLE, S_IDENT, S_STAT, S_RADR, S_RDAT,
    S_PADR, S_PDAT, S_EADR, S_EDONE
  } eng_st_t;
endpackage

// File: rtl/nce_mem.sv
module nce_mem #(
  parameter int DEPTH = 4096,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          i_we,
  input  logic [AW-1:0] i_waddr,
  input  logic [7:0]    i_wdata,
  input  logic [AW-1:0] i_raddr,
  output logic [7:0]    o_rdata
);
  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (i_we) store[i_waddr] <= i_wdata;
    o_rdata <= store[i_raddr];
  end
endmodule

// File: rtl/nce_sweep.sv
module nce_sweep #(
  parameter int DEPTH = 4096,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          i_go,
  input  logic [AW-1:0] i_first,
  input  logic [AW-1:0] i_last,
  output logic          o_we,
  output logic [AW-1:0] o_addr,
  output logic          o_busy
);
  logic [AW-1:0] cur_q, lst_q;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b1;
      cur_q <= '0;
      lst_q <= AW'(DEPTH - 1);
    end else if (run_q) begin
      if (cur_q == lst_q) run_q <= 1'b0;
      else                cur_q <= cur_q + 1'b1;
    end else if (i_go) begin
      run_q <= 1'b1;
      cur_q <= i_first;
      lst_q <= i_last;
    end
  end

  assign o_we   = run_q;
  assign o_addr = cur_q;
  assign o_busy = run_q;

  p_sweep_window_r10: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cur_q <= lst_q))
    else $error("sweep pointer passed its end");
endmodule

// File: rtl/nce_addr_col.sv
module nce_addr_col (
  input  logic        clk,
  input  logic        rst,
  input  logic        i_clr,
  input  logic        i_shift,
  input  logic [7:0]  i_byte,
  input  logic        i_four,
  input  logic        i_inc,
  input  logic        i_inc_pg,
  output logic [31:0] o_addr,
  output logic [31:0] o_next,
  output logic        o_last
);
  logic [31:0] addr_q;
  logic [2:0]  cnt_q;

  assign o_next = {addr_q[23:0], i_byte};
  assign o_last = i_shift && (cnt_q == (i_four ? 3'd3 : 3'd2));
  assign o_addr = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (i_clr) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (i_shift) begin
      addr_q <= o_next;
      cnt_q  <= o_last ? 3'd0 : cnt_q + 3'd1;
    end else if (i_inc) begin
      addr_q <= addr_q + 32'd1;
    end else if (i_inc_pg) begin
      addr_q <= {addr_q[31:8], addr_q[7:0] + 8'd1};
    end
  end

  p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= 3'd3)
    else $error("address byte count out of range");

  p_page_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (i_inc_pg && !i_clr && !i_shift && !i_inc) |=> (addr_q[31:8] == $past(addr_q[31:8])))
    else $error("page program left its page");
endmodule

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine #(
  parameter int DEPTH = 4096,
  localparam int AW = $clog2(DEPTH),
  localparam logic [32:0] LIM = 33'(DEPTH)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       i_start,
  input  logic       i_wr_vld,
  input  logic [7:0] i_wr_byte,
  input  logic       i_rd_req,
  input  logic       i_end,
  output logic       o_rd_vld,
  output logic [7:0] o_rd_byte,
  output logic       o_err,
  output logic       o_busy
);
  import nce_pkg::*;

  eng_st_t     st_q;
  logic        wip_q, wen_q, four_q;
  logic [4:0]  esh_q;
  logic [1:0]  idc_q;
  logic        pw_q;
  logic [AW-1:0] pw_addr_q;
  logic [7:0]  pw_byte_q;
  logic        src_mem_q;
  logic [7:0]  reg_q;

  logic [31:0] ca_addr, ca_next;
  logic        ca_last, ca_clr, ca_shift, ca_inc, ca_inc_pg;
  logic        cur_ok, nxt_ok;
  logic        er_go, chip_go, sw_go;
  logic [32:0] e_size, e_base, e_last;
  logic [AW-1:0] sw_first, sw_last, sw_addr;
  logic        sw_we, sw_busy;
  logic        m_we;
  logic [AW-1:0] m_waddr;
  logic [7:0]  m_wdata, m_rdata;

  assign cur_ok = ({1'b0, ca_addr} < LIM);
  assign nxt_ok = ({1'b0, ca_next} < LIM);

  assign ca_clr    = i_start && (st_q == S_IDLE);
  assign ca_shift  = i_wr_vld && ((st_q == S_RADR) || (st_q == S_PADR) ||
                                  ((st_q == S_EADR) && wen_q));
  assign ca_inc    = i_rd_req && (st_q == S_RDAT) && cur_ok;
  assign ca_inc_pg = i_wr_vld && (st_q == S_PDAT) && wen_q;

  nce_addr_col u_col (
    .clk(clk), .rst(rst), .i_clr(ca_clr), .i_shift(ca_shift),
    .i_byte(i_wr_byte), .i_four(four_q), .i_inc(ca_inc), .i_inc_pg(ca_inc_pg),
    .o_addr(ca_addr), .o_next(ca_next), .o_last(ca_last)
  );

  always_comb begin
    e_size  = 33'(1) << esh_q;
    e_base  = {1'b0, ca_next} & ~(e_size - 33'd1);
    e_last  = e_base + e_size - 33'd1;
    if (e_last >= LIM) e_last = LIM - 33'd1;
    er_go   = ca_last && (st_q == S_EADR) && nxt_ok;
    chip_go = i_start && (st_q == S_IDLE) && (i_wr_byte == OP_CHIP) && wen_q;
    sw_go   = er_go || chip_go;
    if (chip_go) begin
      sw_first = '0;
      sw_last  = AW'(DEPTH - 1);
    end else begin
      sw_first = e_base[AW-1:0];
      sw_last  = e_last[AW-1:0];
    end
  end

  nce_sweep #(.DEPTH(DEPTH)) u_sweep (
    .clk(clk), .rst(rst), .i_go(sw_go), .i_first(sw_first), .i_last(sw_last),
    .o_we(sw_we), .o_addr(sw_addr), .o_busy(sw_busy)
  );

  always_comb begin
    m_we    = sw_we || pw_q;
    m_waddr = sw_we ? sw_addr : pw_addr_q;
    m_wdata = sw_we ? 8'hFF : (m_rdata & pw_byte_q);
  end

  nce_mem #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .i_we(m_we), .i_waddr(m_waddr), .i_wdata(m_wdata),
    .i_raddr(ca_addr[AW-1:0]), .o_rdata(m_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      wip_q     <= 1'b0;
      wen_q     <= 1'b0;
      four_q    <= 1'b0;
      esh_q     <= 5'd12;
      idc_q     <= '0;
      pw_q      <= 1'b0;
      pw_addr_q <= '0;
      pw_byte_q <= '0;
      src_mem_q <= 1'b0;
      reg_q     <= '0;
      o_rd_vld  <= 1'b0;
      o_err     <= 1'b0;
    end else begin
      o_err    <= 1'b0;
      o_rd_vld <= i_rd_req;
      pw_q     <= 1'b0;

      if (i_start) begin
        if (st_q != S_IDLE) begin
          o_err <= 1'b1;
        end else begin
          unique case (i_wr_byte)
            OP_IDENT:  begin st_q <= S_IDENT; idc_q <= '0; end
            OP_STAT:   st_q <= S_STAT;
            OP_NARROW: four_q <= 1'b0;
            OP_WIDE:   four_q <= 1'b1;
            OP_WREN:   wen_q <= 1'b1;
            OP_READ:   st_q <= S_RADR;
            OP_PROG:   st_q <= S_PADR;
            OP_ER4K:   begin st_q <= S_EADR; esh_q <= 5'd12; end
            OP_ER32K:  begin st_q <= S_EADR; esh_q <= 5'd15; end
            OP_ER64K:  begin st_q <= S_EADR; esh_q <= 5'd16; end
            OP_CHIP:   if (wen_q) begin wip_q <= 1'b1; wen_q <= 1'b0; end
            default:   o_err <= 1'b1;
          endcase
        end
      end

      if (i_wr_vld) begin
        unique case (st_q)
          S_RADR: if (ca_last) st_q <= S_RDAT;
          S_PADR: if (ca_last) st_q <= S_PDAT;
          S_EADR: if (ca_last) begin
            st_q <= S_EDONE;
            if (nxt_ok) begin
              wip_q <= 1'b1;
              wen_q <= 1'b0;
            end else begin
              o_err <= 1'b1;
            end
          end
          S_PDAT: if (wen_q) begin
            if (cur_ok) begin
              pw_q      <= 1'b1;
              pw_addr_q <= ca_addr[AW-1:0];
              pw_byte_q <= i_wr_byte;
            end else begin
              o_err <= 1'b1;
            end
          end
          default: o_err <= 1'b1;
        endcase
      end

      if (i_rd_req) begin
        src_mem_q <= 1'b0;
        reg_q     <= 8'h00;
        unique case (st_q)
          S_IDENT: begin
            unique case (idc_q)
              2'd0:    reg_q <= 8'h55;
              2'd1:    reg_q <= 8'hAA;
              2'd2:    reg_q <= 8'h55;
              default: reg_q <= 8'h00;
            endcase
            if (idc_q != 2'd3) idc_q <= idc_q + 2'd1;
          end
          S_STAT: begin
            reg_q <= {6'b0, wen_q, wip_q};
            wip_q <= 1'b0;
          end
          S_RDAT: begin
            if (cur_ok) src_mem_q <= 1'b1;
            else        o_err <= 1'b1;
          end
          default: o_err <= 1'b1;
        endcase
      end

      if (i_end) begin
        if ((st_q == S_PDAT) && wen_q) begin
          wip_q <= 1'b1;
          wen_q <= 1'b0;
        end
        st_q <= S_IDLE;
      end
    end
  end

  assign o_rd_byte = src_mem_q ? m_rdata : reg_q;
  assign o_busy    = sw_busy;

  // host contract: one strobe per cycle
  p_one_strobe_r12: assert property (@(posedge clk) disable iff (rst)
    $countones({i_start, i_wr_vld, i_rd_req, i_end}) <= 1)
    else $error("more than one host strobe in a cycle");

  // host contract: quiet while the fill runs
  p_quiet_busy_r10: assert property (@(posedge clk) disable iff (rst)
    o_busy |-> !(i_start || i_wr_vld || i_rd_req))
    else $error("host traffic during fill");

  p_reply_next_r6: assert property (@(posedge clk) disable iff (rst)
    i_rd_req |=> o_rd_vld)
    else $error("read request not answered");

  p_end_idle_r13: assert property (@(posedge clk) disable iff (rst)
    i_end |=> (st_q == S_IDLE))
    else $error("frame end did not return to idle");

  p_erase_flags_r11: assert property (@(posedge clk) disable iff (rst)
    sw_go |=> (wip_q && !wen_q && o_busy))
    else $error("erase did not update status");

  p_stat_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (i_rd_req && (st_q == S_STAT)) |=> !wip_q)
    else $error("status read left WIP set");

  p_no_wen_no_write_r9: assert property (@(posedge clk) disable iff (rst)
    (i_wr_vld && (st_q == S_PDAT) && !wen_q) |=> !pw_q)
    else $error("program without write enable touched the array");
endmodule

// File: tb/sim_nor_cmd_engine.sv
module sim_nor_cmd_engine;
  localparam int DEPTH = 8192;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       i_start = 1'b0, i_wr_vld = 1'b0, i_rd_req = 1'b0, i_end = 1'b0;
  logic [7:0] i_wr_byte = 8'h00;
  logic       o_rd_vld, o_err, o_busy;
  logic [7:0] o_rd_byte;

  always #4 clk = ~clk;

  nor_cmd_engine #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .i_start(i_start), .i_wr_vld(i_wr_vld),
    .i_wr_byte(i_wr_byte), .i_rd_req(i_rd_req), .i_end(i_end),
    .o_rd_vld(o_rd_vld), .o_rd_byte(o_rd_byte), .o_err(o_err), .o_busy(o_busy)
  );

  int   n_chk = 0, n_bad = 0;
  logic err_seen = 1'b0;
  logic last_vld = 1'b0;
  logic [7:0] mdl [DEPTH];
  logic [7:0] v;

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    summary();
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
    if (o_err) err_seen = 1'b1;
  endtask

  task automatic op(input logic [7:0] b);
    i_start = 1'b1; i_wr_byte = b; tick(); i_start = 1'b0;
  endtask
  task automatic wb(input logic [7:0] b);
    i_wr_vld = 1'b1; i_wr_byte = b; tick(); i_wr_vld = 1'b0;
  endtask
  task automatic rd(output logic [7:0] r);
    i_rd_req = 1'b1; tick(); i_rd_req = 1'b0;
    r = o_rd_byte; last_vld = o_rd_vld;
  endtask
  task automatic fend;
    i_end = 1'b1; tick(); i_end = 1'b0;
  endtask
  task automatic cmd1(input logic [7:0] b);
    op(b); fend();
  endtask
  task automatic adr3(input logic [23:0] a);
    wb(a[23:16]); wb(a[15:8]); wb(a[7:0]);
  endtask
  task automatic wait_fill;
    while (o_busy) tick();
  endtask

  task automatic stat_is(input string tag, input logic [7:0] e);
    logic [7:0] r;
    op(8'h05); rd(r); fend();
    chk(tag, r, e);
  endtask

  task automatic cmp_all(input string tag);
    logic [7:0] r;
    op(8'h03); adr3(24'h0);
    for (int a = 0; a < DEPTH; a++) begin
      rd(r);
      if (r !== mdl[a]) chk($sformatf("%s @%0h", tag, a), r, mdl[a]);
      else n_chk++;
    end
    fend();
  endtask

  task automatic prog_page(input logic [23:0] a0, input int n, input int seed);
    logic [23:0] a;
    a = a0;
    cmd1(8'h06);
    op(8'h02); adr3(a0);
    for (int k = 0; k < n; k++) begin
      logic [7:0] b;
      b = 8'((k * 37 + seed) & 255);
      wb(b);
      if (a < DEPTH) mdl[a] = mdl[a] & b;
      a = {a[23:8], a[7:0] + 8'd1};
    end
    fend();
  endtask

  task automatic mdl_erase(input int a, input int sz);
    int base;
    base = a - (a % sz);
    for (int k = base; k < base + sz && k < DEPTH; k++) mdl[k] = 8'hFF;
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) mdl[a] = 8'hFF;
    repeat (4) tick();
    rst = 1'b0;
    tick();
    chk("R1 fill busy after reset", o_busy, 1);
    wait_fill();
    stat_is("R1 status after reset", 8'h00);
    cmp_all("R1 array all ones");

    // identification sequence
    op(8'h9F);
    rd(v); chk("R4 id byte0", v, 8'h55);
    rd(v); chk("R4 id byte1", v, 8'hAA);
    rd(v); chk("R4 id byte2", v, 8'h55);
    rd(v); chk("R4 id byte3", v, 8'h00);
    rd(v); chk("R4 id byte4", v, 8'h00);
    chk("R6 reply valid", last_vld, 1);
    fend();

    // program without write enable
    op(8'h02); adr3(24'h000100); wb(8'h00); wb(8'h00); fend();
    stat_is("R9 status after unenabled program", 8'h00);
    op(8'h03); adr3(24'h000100); rd(v); fend();
    chk("R9 array untouched", v, 8'hFF);

    // enable, program across the page wrap
    cmd1(8'h06);
    stat_is("R2 WEN set by 06", 8'h02);
    op(8'h02); adr3(24'h0000FE);
    wb(8'hA5); wb(8'h3C); wb(8'h0F); wb(8'hF0);
    fend();
    mdl[16'h00FE] = 8'hA5; mdl[16'h00FF] = 8'h3C;
    mdl[16'h0000] = 8'h0F; mdl[16'h0001] = 8'hF0;
    stat_is("R11 WIP set WEN clear after program", 8'h01);
    stat_is("R3 WIP cleared by status read", 8'h00);
    op(8'h03); adr3(24'h0000FE);
    rd(v); chk("R6 seq byte FE", v, 8'hA5);
    rd(v); chk("R8 seq byte FF", v, 8'h3C);
    rd(v); chk("R8 page wrap not into next page", v, 8'hFF);
    fend();
    op(8'h03); adr3(24'h000000);
    rd(v); chk("R8 wrapped byte 0", v, 8'h0F);
    rd(v); chk("R8 wrapped byte 1", v, 8'hF0);
    fend();

    // AND behaviour
    cmd1(8'h06);
    op(8'h02); adr3(24'h0000FE); wb(8'hF0); fend();
    mdl[16'h00FE] = 8'hA5 & 8'hF0;
    op(8'h03); adr3(24'h0000FE); rd(v); fend();
    chk("R7 program only clears bits", v, 8'hA0);
    stat_is("R3 clear after second program", 8'h01);

    // full pages with wrap
    prog_page(24'h000F80, 256, 11);
    prog_page(24'h001F80, 256, 3);
    prog_page(24'h000A00, 300, 99);
    cmp_all("R7 R8 pages");

    // 4 KiB erase at 0x1234
    cmd1(8'h06);
    op(8'h20); adr3(24'h001234);
    chk("R10 busy during region fill", o_busy, 1);
    fend();
    wait_fill();
    mdl_erase(32'h1234, 4096);
    stat_is("R11 WIP after erase", 8'h01);
    stat_is("R3 WIP cleared", 8'h00);
    cmp_all("R10 4K erase region");

    // 4-byte addressing
    cmd1(8'hB7);
    cmd1(8'h06);
    op(8'h02); wb(8'h00); wb(8'h00); wb(8'h0F); wb(8'h85); wb(8'h12); fend();
    mdl[16'h0F85] = mdl[16'h0F85] & 8'h12;
    stat_is("R11 program in wide mode", 8'h01);
    err_seen = 1'b0;
    op(8'h03); adr3(24'h00000F); rd(v); fend();
    chk("R5 read too early in 4-byte mode", err_seen, 1);
    op(8'h03); wb(8'h00); wb(8'h00); wb(8'h0F); wb(8'h85); rd(v); fend();
    chk("R5 4-byte read", v, mdl[16'h0F85]);
    cmd1(8'hE9);
    op(8'h03); adr3(24'h000F85); rd(v); fend();
    chk("R5 3-byte read again", v, mdl[16'h0F85]);

    // unenabled erases
    op(8'hD8); adr3(24'h000000); fend();
    chk("R9 no fill without WEN", o_busy, 0);
    cmd1(8'h60);
    chk("R9 no chip fill without WEN", o_busy, 0);
    stat_is("R9 status unchanged", 8'h00);
    cmp_all("R9 array after refused erases");

    // error cases
    err_seen = 1'b0; cmd1(8'h77);
    chk("R12 unknown opcode", err_seen, 1);
    err_seen = 1'b0; op(8'h03); op(8'h05); fend();
    chk("R12 opcode while open", err_seen, 1);
    err_seen = 1'b0; op(8'h03); adr3(DEPTH); rd(v); fend();
    chk("R12 read beyond array", err_seen, 1);
    chk("R12 out of range data", v, 8'h00);
    err_seen = 1'b0; op(8'h9F); wb(8'h00); fend();
    chk("R12 byte in ident state", err_seen, 1);
    err_seen = 1'b0; cmd1(8'h06); op(8'h02); adr3(DEPTH + 5); wb(8'h00); fend();
    chk("R12 program beyond array", err_seen, 1);
    stat_is("R11 end of program frame", 8'h01);

    // frame end returns idle
    err_seen = 1'b0;
    op(8'h03); wb(8'h00); fend();
    op(8'h05); rd(v); fend();
    chk("R13 accepted after end", err_seen, 0);
    chk("R13 status after abort", v, 8'h00);

    // 32 KiB erase clipped to array
    cmd1(8'h06);
    op(8'h52); adr3(24'h000777); fend();
    wait_fill();
    mdl_erase(32'h777, 32768);
    cmp_all("R10 32K erase clipped");

    // chip erase after new data
    prog_page(24'h000300, 64, 5);
    cmd1(8'h06);
    op(8'h60);
    chk("R10 chip fill busy", o_busy, 1);
    fend();
    wait_fill();
    for (int a = 0; a < DEPTH; a++) mdl[a] = 8'hFF;
    stat_is("R11 WIP after chip erase", 8'h01);
    cmp_all("R10 chip erase");

    summary();
  end
endmodule